// File: doc/BRIEF.md
# ADC Mode Control Sequencer

This block holds the 8-bit mode word of an ADC subsystem and runs the sequence that the word selects. Writing the word starts the selected activity at once. It then counts the "conversion cycle complete" strobes that arrive from the modulator and filter. It decides when a result has settled. It then either presents that result on a data output or commits it to the offset or gain coefficient register.

Single conversions and both self-calibrations end on their own: the operation field falls back to idle (011). The power-mode field locks the gain to a fixed value. The mode word also drives the resistor-path and reference-select outputs. Two ready flags report completed conversions and calibrations, and reading the status clears them.

Top module: `adc_mode_seq`

## Requirements
- R1: After reset, mode_reg is 0x00, pwr_en is 0, adc_rst is 1, both ready flags are 0 and both coefficient outputs are 0.
- R2: A write stores wr_data[6:0] into mode_reg[6:0], and mode_reg[7] always reads 0.
- R3: The operation field mode_reg[2:0] drives the power and reset outputs. For 000 (off), pwr_en=0 and adc_rst=1. For 011 (idle), and for the unused codes 110 and 111, pwr_en=1 and adc_rst=1. For 001, 010, 100 and 101, pwr_en=1 and adc_rst=0.
- R4: In single mode (010), N strobes produce one result, where N is 2 with chop_en low and 3 with chop_en high. After the clock edge that samples the last strobe, dout holds that strobe's res_data, dout_vld is high for one cycle, conv_rdy is 1 and the operation field is 011.
- R5: In continuous mode (001), the first result comes on the N-th strobe and a further result comes on every strobe after it. Each result gives a one-cycle dout_vld pulse and sets conv_rdy. The field stays 001.
- R6: In offset calibration (100), cal_zero_sel is 1. After N strobes, offs_coef takes the last res_data, conv_rdy and cal_rdy are set, the field returns to 011 and dout_vld stays low.
- R7: Gain calibration (101) takes 2N strobes. cal_zero_sel is 1 for the first N and cal_ref_sel is 1 for the last N. At the end, gain_coef takes the last res_data, both ready flags are set and the field returns to 011.
- R8: A write during a sequence discards the strobes counted so far. Strobes arriving in off or idle mode produce no result and change no coefficient.
- R9: Power field mode_reg[4:3] = 01 gives gain_lock=1 and gain_val=128, and 10 gives gain_lock=1 and gain_val=512. The codes 00 and 11 give gain_lock=0 and gain_val=0.
- R10: res20k_sel equals mode_reg[6]. prec_ref_sel is 1 only when mode_reg[5] is 1 and the power field is 01.
- R11: A stat_rd pulse clears conv_rdy and cal_rdy on the next edge. If a flag is set in the same cycle, the set wins.
- R12: A strobe arriving in the same cycle as a write is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Mode word write strobe |
| wr_data | input | 8 | Mode word write value |
| stat_rd | input | 1 | Status read; clears the ready flags |
| chop_en | input | 1 | Chop setting; selects 3-cycle settling when high |
| cyc_done | input | 1 | One conversion cycle completed |
| res_data | input | DW | Filter result for the completed cycle |
| mode_reg | output | 8 | Current mode word |
| pwr_en | output | 1 | ADC and reference power enable |
| adc_rst | output | 1 | Holds the ADC in reset |
| cal_zero_sel | output | 1 | Selects the internal 0 V input |
| cal_ref_sel | output | 1 | Selects the internal reference input |
| res20k_sel | output | 1 | Selects the 20 k resistor path to ground |
| prec_ref_sel | output | 1 | Selects the precision reference in low-power mode |
| gain_lock | output | 1 | Gain is forced by the power mode |
| gain_val | output | GAIN_W | Forced gain value |
| conv_rdy | output | 1 | Conversion ready flag |
| cal_rdy | output | 1 | Calibration ready flag |
| dout | output | DW | Latest conversion result |
| dout_vld | output | 1 | One-cycle pulse when dout is new |
| offs_coef | output | DW | Offset coefficient |
| gain_coef | output | DW | Gain coefficient |

## Verification
The assertions on the settle counter assume that chop_en is held steady while a sequence is counting. If chop_en changed mid-sequence, the counter could already sit past a smaller target. The stimulus therefore changes chop_en only while the block is idle or off, or just before a write restarts the count. The assertions also assume that cyc_done is a single-cycle pulse. The stimulus raises cyc_done for exactly one cycle, with idle cycles between pulses.

// File: rtl/adcm_pkg.sv
package adcm_pkg;
    localparam logic [2:0] OP_OFF     = 3'b000;
    localparam logic [2:0] OP_CONT    = 3'b001;
    localparam logic [2:0] OP_SINGLE  = 3'b010;
    localparam logic [2:0] OP_IDLE    = 3'b011;
    localparam logic [2:0] OP_OFFCAL  = 3'b100;
    localparam logic [2:0] OP_GAINCAL = 3'b101;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_LOW    = 2'b01,
        PM_LOWP   = 2'b10,
        PM_RSVD   = 2'b11
    } pmode_e;

    function automatic logic op_counts(input logic [2:0] op);
        return (op == OP_CONT) || (op == OP_SINGLE) ||
               (op == OP_OFFCAL) || (op == OP_GAINCAL);
    endfunction
endpackage

// File: rtl/adcm_settle.sv
module adcm_settle #(
    parameter int unsigned BASE_NOCHOP = 2,
    parameter int unsigned BASE_CHOP   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic chop,
    input  logic dbl,
    output logic reach,
    output logic half
);
    localparam int unsigned CW = $clog2(2 * BASE_CHOP + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] base, target;

    always_comb begin
        base   = chop ? CW'(BASE_CHOP) : CW'(BASE_NOCHOP);
        target = dbl ? CW'(base << 1) : base;
        reach  = step && (cnt_q >= target - CW'(1));
        half   = cnt_q >= base;
        cnt_d  = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (step && (cnt_q < target))
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4 R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= target);

    // R7
    half_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half) |-> $past(step));
endmodule

// File: rtl/adcm_outdec.sv
module adcm_outdec
    import adcm_pkg::*;
#(
    parameter int unsigned GAIN_W   = 10,
    parameter int unsigned GAIN_LP  = 128,
    parameter int unsigned GAIN_LPP = 512
) (
    input  logic [2:0]        op,
    input  logic [1:0]        pm,
    input  logic              prec_bit,
    input  logic              res_bit,
    input  logic              half,
    output logic              pwr_en,
    output logic              adc_rst,
    output logic              cal_zero_sel,
    output logic              cal_ref_sel,
    output logic              res20k_sel,
    output logic              prec_ref_sel,
    output logic              gain_lock,
    output logic [GAIN_W-1:0] gain_val
);
    always_comb begin
        pwr_en       = (op != OP_OFF);
        adc_rst      = !op_counts(op);
        cal_zero_sel = (op == OP_OFFCAL) || ((op == OP_GAINCAL) && !half);
        cal_ref_sel  = (op == OP_GAINCAL) && half;
        res20k_sel   = res_bit;
        prec_ref_sel = prec_bit && (pmode_e'(pm) == PM_LOW);
        case (pmode_e'(pm))
            PM_LOW: begin
                gain_lock = 1'b1;
                gain_val  = GAIN_W'(GAIN_LP);
            end
            PM_LOWP: begin
                gain_lock = 1'b1;
                gain_val  = GAIN_W'(GAIN_LPP);
            end
            default: begin
                gain_lock = 1'b0;
                gain_val  = '0;
            end
        endcase
    end
endmodule

// File: rtl/adc_mode_seq.sv
module adc_mode_seq
    import adcm_pkg::*;
#(
    parameter int unsigned DW            = 24,
    parameter int unsigned SETTLE_NOCHOP = 2,
    parameter int unsigned SETTLE_CHOP   = 3,
    parameter int unsigned GAIN_W        = 10,
    parameter int unsigned GAIN_LP       = 128,
    parameter int unsigned GAIN_LPP      = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              stat_rd,
    input  logic              chop_en,
    input  logic              cyc_done,
    input  logic [DW-1:0]     res_data,
    output logic [7:0]        mode_reg,
    output logic              pwr_en,
    output logic              adc_rst,
    output logic              cal_zero_sel,
    output logic              cal_ref_sel,
    output logic              res20k_sel,
    output logic              prec_ref_sel,
    output logic              gain_lock,
    output logic [GAIN_W-1:0] gain_val,
    output logic              conv_rdy,
    output logic              cal_rdy,
    output logic [DW-1:0]     dout,
    output logic              dout_vld,
    output logic [DW-1:0]     offs_coef,
    output logic [DW-1:0]     gain_coef
);
    typedef struct packed {
        logic [6:0]    mode;
        logic          conv;
        logic          cal;
        logic [DW-1:0] dout;
        logic          vld;
        logic [DW-1:0] offs;
        logic [DW-1:0] gain;
    } st_t;

    st_t        st_d, st_q;
    logic [2:0] op;
    logic       step, reach, half, clr, dbl;

    assign op = st_q.mode[2:0];

    always_comb begin
        step = cyc_done && op_counts(op) && !wr_en;
        dbl  = (op == OP_GAINCAL);
        clr  = wr_en || (reach && (op != OP_CONT));

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (stat_rd) begin
            st_d.conv = 1'b0;
            st_d.cal  = 1'b0;
        end
        if (wr_en) begin
            st_d.mode = wr_data[6:0];
        end else if (reach) begin
            case (op)
                OP_CONT: begin
                    st_d.dout = res_data;
                    st_d.vld  = 1'b1;
                    st_d.conv = 1'b1;
                end
                OP_SINGLE: begin
                    st_d.dout      = res_data;
                    st_d.vld       = 1'b1;
                    st_d.conv      = 1'b1;
                    st_d.mode[2:0] = OP_IDLE;
                end
                OP_OFFCAL: begin
                    st_d.offs      = res_data;
                    st_d.conv      = 1'b1;
                    st_d.cal       = 1'b1;
                    st_d.mode[2:0] = OP_IDLE;
                end
                OP_GAINCAL: begin
                    st_d.gain      = res_data;
                    st_d.conv      = 1'b1;
                    st_d.cal       = 1'b1;
                    st_d.mode[2:0] = OP_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    adcm_settle #(
        .BASE_NOCHOP (SETTLE_NOCHOP),
        .BASE_CHOP   (SETTLE_CHOP)
    ) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (step),
        .chop  (chop_en),
        .dbl   (dbl),
        .reach (reach),
        .half  (half)
    );

    adcm_outdec #(
        .GAIN_W   (GAIN_W),
        .GAIN_LP  (GAIN_LP),
        .GAIN_LPP (GAIN_LPP)
    ) u_dec (
        .op           (op),
        .pm           (st_q.mode[4:3]),
        .prec_bit     (st_q.mode[5]),
        .res_bit      (st_q.mode[6]),
        .half         (half),
        .pwr_en       (pwr_en),
        .adc_rst      (adc_rst),
        .cal_zero_sel (cal_zero_sel),
        .cal_ref_sel  (cal_ref_sel),
        .res20k_sel   (res20k_sel),
        .prec_ref_sel (prec_ref_sel),
        .gain_lock    (gain_lock),
        .gain_val     (gain_val)
    );

    assign mode_reg  = {1'b0, st_q.mode};
    assign conv_rdy  = st_q.conv;
    assign cal_rdy   = st_q.cal;
    assign dout      = st_q.dout;
    assign dout_vld  = st_q.vld;
    assign offs_coef = st_q.offs;
    assign gain_coef = st_q.gain;

    // R4
    single_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SINGLE && reach && !wr_en) |=> (mode_reg[2:0] == OP_IDLE));

    // R5
    vld_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |-> $past(cyc_done));

    // R6
    cal_rdy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_rdy) |-> ($past(op) == OP_OFFCAL || $past(op) == OP_GAINCAL));

    // R11
    rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !reach) |=> (!conv_rdy && !cal_rdy));
endmodule

// File: tb/sim_adc_mode_seq.sv
module sim_adc_mode_seq;
    localparam int CLK_PER = 10;
    localparam int DW      = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          stat_rd = 1'b0;
    logic          chop_en = 1'b0;
    logic          cyc_done = 1'b0;
    logic [DW-1:0] res_data = '0;
    logic [7:0]    mode_reg;
    logic          pwr_en, adc_rst, cal_zero_sel, cal_ref_sel;
    logic          res20k_sel, prec_ref_sel, gain_lock;
    logic [9:0]    gain_val;
    logic          conv_rdy, cal_rdy, dout_vld;
    logic [DW-1:0] dout, offs_coef, gain_coef;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] exp_q[$];

    always #(CLK_PER/2) clk = ~clk;

    adc_mode_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .stat_rd(stat_rd), .chop_en(chop_en), .cyc_done(cyc_done),
        .res_data(res_data), .mode_reg(mode_reg), .pwr_en(pwr_en),
        .adc_rst(adc_rst), .cal_zero_sel(cal_zero_sel),
        .cal_ref_sel(cal_ref_sel), .res20k_sel(res20k_sel),
        .prec_ref_sel(prec_ref_sel), .gain_lock(gain_lock),
        .gain_val(gain_val), .conv_rdy(conv_rdy), .cal_rdy(cal_rdy),
        .dout(dout), .dout_vld(dout_vld), .offs_coef(offs_coef),
        .gain_coef(gain_coef)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic strobe(input logic [DW-1:0] v);
        @(negedge clk); cyc_done = 1'b1; res_data = v;
        @(negedge clk); cyc_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic status_read();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    // scoreboard monitor: R4 R5 results in order, none unexpected
    always @(posedge clk) begin
        #1;
        if (rst_n && dout_vld) begin
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R8: actual unexpected result 0x%0h expected none", dout);
            end else begin
                check("R4/R5 dout", int'(dout), int'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(CLK_PER * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 mode", mode_reg, 0);
        check("R1 pwr_en", pwr_en, 0);
        check("R1 adc_rst", adc_rst, 1);
        check("R1 rdy", {conv_rdy, cal_rdy}, 0);
        check("R1 coef", offs_coef | gain_coef, 0);

        // R2 R3 R9 R10: all ones written
        wr(8'hFF);
        check("R2 bit7", mode_reg, 8'h7F);
        check("R3 code111 pwr", pwr_en, 1);
        check("R3 code111 rst", adc_rst, 1);
        check("R9 pm11 lock", {gain_lock, gain_val}, 0);
        check("R10 res20k", res20k_sel, 1);
        check("R10 prec pm11", prec_ref_sel, 0);

        wr(8'h28);
        check("R10 prec pm01", prec_ref_sel, 1);
        check("R10 res20k clr", res20k_sel, 0);
        check("R9 pm01 gain", {gain_lock, gain_val}, {1'b1, 10'd128});
        check("R3 off pwr", pwr_en, 0);
        check("R3 off rst", adc_rst, 1);
        wr(8'h10);
        check("R9 pm10 gain", {gain_lock, gain_val}, {1'b1, 10'd512});

        // R8: strobes in off mode
        wr(8'h00);
        strobe(24'h111); strobe(24'h222); strobe(24'h333);
        check("R8 off no rdy", conv_rdy, 0);
        check("R8 off coef", offs_coef, 0);

        // R4 single, chop off
        chop_en = 1'b0;
        wr(8'h02);
        check("R3 single pwr/rst", {pwr_en, adc_rst}, 2'b10);
        strobe(24'h0A0001);
        check("R4 still single", mode_reg, 8'h02);
        check("R4 not ready", conv_rdy, 0);
        exp_q.push_back(24'h0B0002);
        strobe(24'h0B0002);
        check("R4 idle after", mode_reg, 8'h03);
        check("R4 conv_rdy", conv_rdy, 1);
        status_read();
        check("R11 cleared", conv_rdy, 0);

        // R4 single, chop on
        chop_en = 1'b1;
        wr(8'h02);
        strobe(24'h1); strobe(24'h2);
        check("R4 chop still single", mode_reg, 8'h02);
        exp_q.push_back(24'h0C0003);
        strobe(24'h0C0003);
        check("R4 chop idle", mode_reg, 8'h03);

        // R5 continuous, chop off
        chop_en = 1'b0;
        wr(8'h01);
        strobe(24'h5);
        exp_q.push_back(24'h000D01); strobe(24'h000D01);
        exp_q.push_back(24'h000D02); strobe(24'h000D02);
        exp_q.push_back(24'h000D03); strobe(24'h000D03);
        check("R5 stays cont", mode_reg, 8'h01);
        // R11 set wins over clear
        exp_q.push_back(24'h000D04);
        @(negedge clk); stat_rd = 1'b1; cyc_done = 1'b1; res_data = 24'h000D04;
        @(negedge clk); stat_rd = 1'b0; cyc_done = 1'b0;
        check("R11 set wins", conv_rdy, 1);
        status_read();

        // R6 offset calibration, chop off
        wr(8'h04);
        check("R6 zero sel", {cal_zero_sel, cal_ref_sel}, 2'b10);
        strobe(24'h7);
        strobe(24'h000123);
        check("R6 offs coef", offs_coef, 24'h000123);
        check("R6 rdy both", {conv_rdy, cal_rdy}, 2'b11);
        check("R6 idle", mode_reg, 8'h03);
        status_read();

        // R7 gain calibration, chop on
        chop_en = 1'b1;
        wr(8'h05);
        check("R7 first half zero", {cal_zero_sel, cal_ref_sel}, 2'b10);
        strobe(24'h1); strobe(24'h2); strobe(24'h3);
        check("R7 second half ref", {cal_zero_sel, cal_ref_sel}, 2'b01);
        check("R7 still gaincal", mode_reg, 8'h05);
        strobe(24'h4); strobe(24'h5); strobe(24'h000456);
        check("R7 gain coef", gain_coef, 24'h000456);
        check("R7 rdy both", {conv_rdy, cal_rdy}, 2'b11);
        check("R7 idle", mode_reg, 8'h03);
        status_read();

        // R8 abort restarts count
        chop_en = 1'b0;
        wr(8'h02);
        strobe(24'h9);
        wr(8'h02);
        strobe(24'hA);
        check("R8 restart count", mode_reg, 8'h02);
        exp_q.push_back(24'h0E0001);
        strobe(24'h0E0001);
        check("R8 done after restart", mode_reg, 8'h03);

        // R12 strobe coincident with write is dropped
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h02; cyc_done = 1'b1; res_data = 24'hBAD;
        @(negedge clk); wr_en = 1'b0; cyc_done = 1'b0;
        strobe(24'hB);
        check("R12 strobe dropped", mode_reg, 8'h02);
        exp_q.push_back(24'h0F0001);
        strobe(24'h0F0001);
        check("R12 completes", mode_reg, 8'h03);

        // R8 abort calibration into idle, strobes ignored
        wr(8'h04);
        strobe(24'hC);
        wr(8'h03);
        strobe(24'hD); strobe(24'hE); strobe(24'hF);
        check("R8 idle offs kept", offs_coef, 24'h000123);
        check("R8 idle mode", mode_reg, 8'h03);

        repeat (3) @(negedge clk);
        check("R4/R5 queue empty", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule